// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock and data line timing of an I2C master at the level of single bus conditions. A sequencer above it asks for one of four operations at a time: a START (or a repeated START when the bus is already held), a STOP, the write of one bit, or the read of one bit. The block answers with a one-cycle completion pulse. Both lines are open-drain. The block outputs pull-low enables and reads the resolved line levels back.

Four counts, all in system clock cycles, set the timing. They are the full SCL period, the part of the period spent low, one shared setup/hold time for START, repeated START and STOP, and the time by which SDA must settle before SCL is released. The high time is the period minus the low count. Its counter starts only once the SCL readback shows the line high, so a slave that holds SCL low stretches the clock without shortening the high phase. A typical setting uses a low:high ratio of 5:4, a start/stop time of half the period and a data setup time of one sixteenth of the period. This covers 100 kHz and 400 kHz from a range of system clocks.

The counts must satisfy: data setup at least 1, low count at least data setup plus 2, high time (period minus low) at least 2, start/stop time at least 2. Changing them is only allowed while the bus is idle.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset both pull enables are 0, `cmd_ready` is 1 and `bit_done` is 0.
- R2: A START (`cmd_op`=0) on an idle bus pulls SDA low while SCL is high. SCL is pulled low exactly start/stop-time cycles after SDA falls, and `bit_done` pulses in the cycle SCL falls. Afterwards the bus is held with both lines pulled low.
- R3: A START on an idle bus pulls SDA low no sooner than low-count cycles after the last STOP released SDA (or after reset).
- R4: For a held bus, SCL is held low for at least the low count before each release. When commands follow each other with no idle cycle, it is held low for exactly the low count.
- R5: SDA changes during a bit, STOP or repeated START only while SCL is pulled low. The change comes exactly data-setup cycles before the SCL release.
- R6: For write (`cmd_op`=2) and read (`cmd_op`=3), SCL stays high for exactly period minus low cycles, counted from the cycle the SCL readback first shows high. A stretching slave delays this count but does not shorten it.
- R7: A write with `cmd_bit`=0 pulls SDA during the high phase. A write with `cmd_bit`=1 releases it.
- R8: A read releases SDA and returns on `rd_bit`, valid with `bit_done`, the SDA level seen in the last high cycle.
- R9: A repeated START (`cmd_op`=0 while the bus is held) releases SDA while SCL is low. It then pulls SDA low start/stop-time cycles after the SCL readback goes high, and pulls SCL low a further start/stop-time cycles later.
- R10: A STOP (`cmd_op`=1) while the bus is held pulls SDA low before releasing SCL. It releases SDA start/stop-time cycles after the SCL readback goes high, and leaves both lines released.
- R11: While SCL is high, SDA changes only as part of a START (falling) or a STOP (rising).
- R12: A write, read or STOP requested while the bus is idle is ignored. `bit_done` pulses one cycle later and neither line changes.
- R13: `cmd_ready` is 0 from acceptance until completion. `bit_done` is only raised together with `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_period | input | CW | Full SCL period in cycles |
| cfg_low | input | CW | SCL low time in cycles; also the minimum idle gap after STOP |
| cfg_edge | input | CW | START hold, repeated START setup and STOP setup time in cycles |
| cfg_dsetup | input | CW | SDA settle time before SCL release in cycles |
| cmd_valid | input | 1 | Operation request, taken when `cmd_ready` is 1 |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 write bit, 3 read bit |
| cmd_bit | input | 1 | Bit value for a write |
| cmd_ready | output | 1 | Block idle and able to take a request |
| bit_done | output | 1 | One-cycle pulse when an operation completes |
| rd_bit | output | 1 | Bit captured by the last read |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with CW=8. It uses periods from 12 to 60 cycles, so every configuration runs through START, a few dozen bits, repeated START and STOP in a short run. Directed configurations sit on the limits: a data setup of low minus 2, a start/stop time of 2 and a high time of 2. Random configurations follow the 5:4 low:high and half-period rule. A modelled slave stretches SCL by 0 to 3 cycles before each bit. This checks that the high count starts from the readback rather than from the release.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_LOW,
        ST_RISE,
        ST_HIGH,
        ST_HOLD
    } state_e;

    // Level of the SDA pull enable an operation sets during the SCL low phase.
    function automatic logic sda_pull_for(op_e op, logic b);
        case (op)
            OP_STOP:  return 1'b1;
            OP_WRITE: return ~b;
            default:  return 1'b0;
        endcase
    endfunction

    // An operation that uses the start/stop time for its high phase.
    function automatic logic is_condition(op_e op);
        return (op == OP_START) || (op == OP_STOP);
    endfunction

endpackage

// File: rtl/sclgen_phase_cnt.sv
module sclgen_phase_cnt #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set,
    input  logic [CW-1:0] set_val,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (set)
            cnt <= set_val;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sclgen_gap_timer.sv
module sclgen_gap_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          ok
);

    logic [CW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            gap_q <= '0;
        else if (run && (gap_q != '1))
            gap_q <= gap_q + 1'b1;
    end

    assign ok = (gap_q >= limit);

endmodule

// File: rtl/sclgen_fsm.sv
module sclgen_fsm
    import sclgen_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_edge,
    input  logic [CW-1:0] cfg_dsetup,
    input  logic          cmd_valid,
    input  op_e           cmd_op,
    input  logic          cmd_bit,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic [CW-1:0] cnt,
    input  logic          gap_ok,
    output logic          cnt_set,
    output logic [CW-1:0] cnt_val,
    output logic          gap_clr,
    output logic          owned,
    output logic          ready,
    output logic          done,
    output logic          rd_bit,
    output logic          scl_lo,
    output logic          sda_lo,
    output logic [1:0]    op_now
);

    localparam logic [CW-1:0] ONE = CW'(1);

    state_e st_q, st_d;
    op_e    op_q, op_d;
    logic   bit_q, bit_d, own_d, scl_d, sda_d, done_d, rd_d;

    logic [CW-1:0] hi_len, chg_at;

    assign hi_len = is_condition(op_q) ? cfg_edge : (cfg_period - cfg_low);
    assign chg_at = cfg_low - cfg_dsetup - ONE;

    always_comb begin
        st_d    = st_q;
        op_d    = op_q;
        bit_d   = bit_q;
        own_d   = owned;
        scl_d   = scl_lo;
        sda_d   = sda_lo;
        done_d  = 1'b0;
        rd_d    = rd_bit;
        cnt_set = 1'b0;
        cnt_val = '0;
        gap_clr = 1'b0;
        case (st_q)
            ST_IDLE: if (cmd_valid) begin
                op_d  = cmd_op;
                bit_d = cmd_bit;
                if (owned) begin
                    st_d    = ST_LOW;
                    cnt_set = 1'b1;
                    cnt_val = ONE;
                end else if (cmd_op == OP_START) begin
                    st_d = ST_GAP;
                end else begin
                    done_d = 1'b1;
                end
            end
            ST_GAP: if (gap_ok) begin
                st_d    = ST_HOLD;
                sda_d   = 1'b1;
                cnt_set = 1'b1;
            end
            ST_LOW: begin
                if (cnt == chg_at)
                    sda_d = sda_pull_for(op_q, bit_q);
                if (cnt == cfg_low - ONE) begin
                    st_d  = ST_RISE;
                    scl_d = 1'b0;
                end
            end
            ST_RISE: if (scl_in) begin
                st_d    = ST_HIGH;
                cnt_set = 1'b1;
                cnt_val = ONE;
            end
            ST_HIGH: if (cnt == hi_len - ONE) begin
                if (op_q == OP_START) begin
                    st_d    = ST_HOLD;
                    sda_d   = 1'b1;
                    cnt_set = 1'b1;
                end else if (op_q == OP_STOP) begin
                    st_d    = ST_IDLE;
                    sda_d   = 1'b0;
                    own_d   = 1'b0;
                    done_d  = 1'b1;
                    gap_clr = 1'b1;
                end else begin
                    st_d   = ST_IDLE;
                    scl_d  = 1'b1;
                    done_d = 1'b1;
                    if (op_q == OP_READ)
                        rd_d = sda_in;
                end
            end
            ST_HOLD: if (cnt == cfg_edge - ONE) begin
                st_d   = ST_IDLE;
                scl_d  = 1'b1;
                own_d  = 1'b1;
                done_d = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_START;
            bit_q  <= 1'b0;
            owned  <= 1'b0;
            scl_lo <= 1'b0;
            sda_lo <= 1'b0;
            done   <= 1'b0;
            rd_bit <= 1'b0;
        end else begin
            st_q   <= st_d;
            op_q   <= op_d;
            bit_q  <= bit_d;
            owned  <= own_d;
            scl_lo <= scl_d;
            sda_lo <= sda_d;
            done   <= done_d;
            rd_bit <= rd_d;
        end
    end

    assign ready  = (st_q == ST_IDLE);
    assign op_now = op_q;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import sclgen_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_edge,
    input  logic [CW-1:0] cfg_dsetup,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_bit,
    output logic          cmd_ready,
    output logic          bit_done,
    output logic          rd_bit,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_pull,
    output logic          sda_pull
);

    logic          cnt_set, gap_clr, gap_ok, owned;
    logic [CW-1:0] cnt_val, cnt_q;
    logic [1:0]    op_q_w;

    sclgen_phase_cnt #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .set     (cnt_set),
        .set_val (cnt_val),
        .cnt     (cnt_q)
    );

    sclgen_gap_timer #(.CW(CW)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .clr   (gap_clr),
        .run   (!owned),
        .limit (cfg_low),
        .ok    (gap_ok)
    );

    sclgen_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg_period (cfg_period),
        .cfg_low    (cfg_low),
        .cfg_edge   (cfg_edge),
        .cfg_dsetup (cfg_dsetup),
        .cmd_valid  (cmd_valid),
        .cmd_op     (op_e'(cmd_op)),
        .cmd_bit    (cmd_bit),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .cnt        (cnt_q),
        .gap_ok     (gap_ok),
        .cnt_set    (cnt_set),
        .cnt_val    (cnt_val),
        .gap_clr    (gap_clr),
        .owned      (owned),
        .ready      (cmd_ready),
        .done       (bit_done),
        .rd_bit     (rd_bit),
        .scl_lo     (scl_pull),
        .sda_lo     (sda_pull),
        .op_now     (op_q_w)
    );

endmodule

// File: rtl/sclgen_checker.sv
module sclgen_checker #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_pull,
    input logic          sda_pull,
    input logic          scl_in,
    input logic          cmd_ready,
    input logic          bit_done,
    input logic [CW-1:0] cfg_low,
    input logic [1:0]    op_q
);

    logic [CW:0] lo_run;

    always_ff @(posedge clk) begin
        if (rst)
            lo_run <= '0;
        else if (!scl_pull)
            lo_run <= '0;
        else if (lo_run != '1)
            lo_run <= lo_run + 1'b1;
    end

    p_reset_released_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!scl_pull && !sda_pull && cmd_ready));

    p_done_when_ready_r13: assert property (@(posedge clk) disable iff (rst)
        bit_done |-> cmd_ready);

    p_scl_low_min_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_pull) |-> (lo_run >= {1'b0, cfg_low}));

    p_sda_rise_high_r11: assert property (@(posedge clk) disable iff (rst)
        (!scl_pull && !$past(scl_pull) && scl_in && $past(scl_in) && $fell(sda_pull))
        |-> (op_q == 2'd1));

    p_sda_fall_high_r11: assert property (@(posedge clk) disable iff (rst)
        (!scl_pull && !$past(scl_pull) && scl_in && $past(scl_in) && $rose(sda_pull))
        |-> (op_q == 2'd0));

endmodule

bind scl_timing_gen sclgen_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .scl_in    (scl_in),
    .cmd_ready (cmd_ready),
    .bit_done  (bit_done),
    .cfg_low   (cfg_low),
    .op_q      (op_q_w)
);

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;

    localparam int CW = 8;
    localparam logic [1:0] K_START = 2'd0, K_STOP = 2'd1, K_WR = 2'd2, K_RD = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CW-1:0] cfg_period, cfg_low, cfg_edge, cfg_dsetup;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic cmd_bit = 1'b0;
    logic cmd_ready, bit_done, rd_bit, scl_pull, sda_pull;
    logic scl_in, sda_in;
    logic slave_sda = 1'b0;
    int   stretch_n = 0;
    int   st_cnt = 0;

    always #10 clk = ~clk;

    assign scl_in = !scl_pull && (st_cnt == 0);
    assign sda_in = !sda_pull && !slave_sda;

    always @(posedge clk) begin
        if (scl_pull) st_cnt <= stretch_n;
        else if (st_cnt != 0) st_cnt <= st_cnt - 1;
    end

    scl_timing_gen #(.CW(CW)) dut (
        .clk(clk), .rst(rst),
        .cfg_period(cfg_period), .cfg_low(cfg_low), .cfg_edge(cfg_edge), .cfg_dsetup(cfg_dsetup),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
        .cmd_ready(cmd_ready), .bit_done(bit_done), .rd_bit(rd_bit),
        .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Line event monitor.
    int t_pull_fall = 0, t_rel = 0, t_line_rise = 0, t_sda_chg = 0, t_sda_fall = 0, t_sda_rise = 0;
    logic sda_at_rise = 1'b0;
    logic p_scl_pull = 1'b0, p_sda_pull = 1'b0, p_scl_line = 1'b1, p_sda_line = 1'b1;
    logic [1:0] cur_op = 2'd0;
    int viol = 0;

    always @(negedge clk) begin
        if (scl_pull && !p_scl_pull) t_pull_fall = cyc;
        if (!scl_pull && p_scl_pull) t_rel = cyc;
        if (scl_in && !p_scl_line) begin
            t_line_rise = cyc;
            sda_at_rise = sda_pull;
        end
        if (sda_pull != p_sda_pull) begin
            t_sda_chg = cyc;
            if (sda_pull) t_sda_fall = cyc;
            else t_sda_rise = cyc;
        end
        if ((sda_in != p_sda_line) && scl_in && p_scl_line && (cur_op == K_WR || cur_op == K_RD))
            viol++;
        p_scl_pull = scl_pull;
        p_sda_pull = sda_pull;
        p_scl_line = scl_in;
        p_sda_line = sda_in;
    end

    function automatic int exp_high(int p, int l);
        return p - l;
    endfunction

    function automatic int exp_sda_pull_high(logic [1:0] op, logic b);
        return (op == K_WR) ? int'(!b) : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic b, output int prev_fall, output int tcmd);
        int g;
        prev_fall = t_pull_fall;
        tcmd = cyc;
        cur_op = op;
        cmd_op = op;
        cmd_bit = b;
        cmd_valid = 1'b1;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        chk(bit_done || !cmd_ready, "R13 busy ready", int'(cmd_ready), 0);
        g = 0;
        while (!bit_done && g < 20000) begin
            @(negedge clk); #1;
            g++;
        end
        chk(g < 20000, "watchdog on command", g, 0);
    endtask

    task automatic run_start(input bit idle);
        int pf, tc;
        do_cmd(K_START, 1'b0, pf, tc);
        if (idle) begin
            chk(t_pull_fall - t_sda_fall == int'(cfg_edge), "R2 start hold",
                t_pull_fall - t_sda_fall, int'(cfg_edge));
            chk(t_sda_fall - t_sda_rise >= int'(cfg_low), "R3 idle gap",
                t_sda_fall - t_sda_rise, int'(cfg_low));
        end else begin
            chk(t_sda_rise > tc && t_sda_rise < t_rel, "R9 sda release in low", t_sda_rise, t_rel);
            chk(t_sda_fall - t_line_rise == int'(cfg_edge), "R9 restart setup",
                t_sda_fall - t_line_rise, int'(cfg_edge));
            chk(t_pull_fall - t_sda_fall == int'(cfg_edge), "R9 restart hold",
                t_pull_fall - t_sda_fall, int'(cfg_edge));
        end
        chk(scl_pull && sda_pull, "R2 bus held", {scl_pull, sda_pull}, 3);
    endtask

    task automatic run_bit(input logic [1:0] op, input logic b, input logic sl);
        int pf, tc;
        stretch_n = int'($urandom_range(3, 0));
        if (op == K_RD) slave_sda = sl;
        do_cmd(op, b, pf, tc);
        chk(t_rel - pf == int'(cfg_low), "R4 low time", t_rel - pf, int'(cfg_low));
        if (t_sda_chg > tc)
            chk(t_rel - t_sda_chg == int'(cfg_dsetup), "R5 data setup",
                t_rel - t_sda_chg, int'(cfg_dsetup));
        chk(t_line_rise - t_rel == stretch_n, "R6 stretch seen", t_line_rise - t_rel, stretch_n);
        chk(t_pull_fall - t_line_rise == exp_high(int'(cfg_period), int'(cfg_low)), "R6 high time",
            t_pull_fall - t_line_rise, exp_high(int'(cfg_period), int'(cfg_low)));
        if (op == K_WR)
            chk(int'(sda_at_rise) == exp_sda_pull_high(op, b), "R7 write level",
                int'(sda_at_rise), exp_sda_pull_high(op, b));
        else begin
            chk(sda_at_rise == 1'b0, "R8 read releases sda", int'(sda_at_rise), 0);
            chk(rd_bit == !sl, "R8 read value", int'(rd_bit), int'(!sl));
        end
        slave_sda = 1'b0;
        stretch_n = 0;
    endtask

    task automatic run_stop();
        int pf, tc;
        stretch_n = int'($urandom_range(3, 0));
        do_cmd(K_STOP, 1'b0, pf, tc);
        chk(t_sda_rise - t_line_rise == int'(cfg_edge), "R10 stop setup",
            t_sda_rise - t_line_rise, int'(cfg_edge));
        chk(t_rel - pf == int'(cfg_low), "R4 low before stop", t_rel - pf, int'(cfg_low));
        chk(!scl_pull && !sda_pull, "R10 lines released", {scl_pull, sda_pull}, 0);
        stretch_n = 0;
    endtask

    task automatic run_ignored(input logic [1:0] op);
        int pf, tc, g0;
        g0 = cyc;
        do_cmd(op, 1'b0, pf, tc);
        chk(cyc - g0 == 1, "R12 done next cycle", cyc - g0, 1);
        chk(!scl_pull && !sda_pull && t_sda_chg <= tc && t_pull_fall <= tc,
            "R12 lines unchanged", {scl_pull, sda_pull}, 0);
    endtask

    task automatic run_session(input int p, input int l, input int e, input int d);
        int nb;
        cfg_period = CW'(p);
        cfg_low = CW'(l);
        cfg_edge = CW'(e);
        cfg_dsetup = CW'(d);
        run_start(1'b1);
        nb = int'($urandom_range(10, 6));
        for (int i = 0; i < nb; i++) begin
            if ($urandom_range(1, 0) == 1) run_bit(K_WR, 1'($urandom), 1'b0);
            else run_bit(K_RD, 1'b0, 1'($urandom));
        end
        run_bit(K_WR, 1'b0, 1'b0);
        run_start(1'b0);
        run_bit(K_WR, 1'b1, 1'b0);
        run_bit(K_RD, 1'b0, 1'b1);
        run_bit(K_WR, 1'b0, 1'b0);
        run_stop();
        run_ignored(K_WR);
        run_ignored(K_STOP);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd4711));
        cfg_period = 8'd20;
        cfg_low = 8'd11;
        cfg_edge = 8'd10;
        cfg_dsetup = 8'd1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_sda_rise = cyc;
        #1;
        chk(!scl_pull && !sda_pull, "R1 reset lines", {scl_pull, sda_pull}, 0);
        chk(cmd_ready && !bit_done, "R1 reset handshake", {cmd_ready, bit_done}, 2);
        run_ignored(K_RD);
        run_session(20, 11, 10, 1);
        run_session(16, 8, 2, 6);
        run_session(13, 11, 5, 9);
        for (int k = 0; k < 3; k++) begin
            int p;
            p = int'($urandom_range(60, 12));
            run_session(p, p * 5 / 9, p / 2, (p / 16 < 1) ? 1 : p / 16);
        end
        chk(viol == 0, "R11 sda stable while scl high", viol, 0);
        finish_run();
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        finish_run();
    end

endmodule